// File: doc/BRIEF.md
# Match-Compare Operating-System Timer

This block is a word-wide, memory-mapped system timer with one match channel and one level interrupt. Software writes a match value. That write arms a single countdown whose length is the distance from the last settled count to the new match value. The distance wraps around the top of the counter range when the match is not ahead of the count. The countdown advances only on cycles where the tick-enable input is high. The tick enable is nominally a 50 MHz strobe. The timer stops once the countdown runs out, and only another match write starts it again.

While the countdown runs, software reads the live count as the match value minus the ticks still outstanding. On expiry the settled count takes the match value. If the interrupt-enable register is nonzero, the status flag and the interrupt output are also raised. Software acknowledges the interrupt by writing zero to the status register.

The register bus is a plain word bus with a byte address, a write strobe, write data and combinational read data. The register offsets are fixed: 0x00 match (write-only), 0x10 live count (read-only), 0x14 status flag, 0x1C interrupt enable.

Top module: `match_os_timer`

## Requirements
- R1: After reset the match value, settled count, remaining countdown, status flag and enable register are all zero, and `irq` is low.
- R2: A write to offset 0x00 stores the match value and arms a countdown. The countdown length is match minus count when the match is greater than the settled count. Otherwise it is match plus (all-ones minus count), taken modulo 2^DATA_W. A countdown of length zero expires on the first tick.
- R3: The countdown decreases by one only on clock edges where `tickEn` is high. After expiry it stays idle, and further ticks change nothing until the next match write.
- R4: A read of offset 0x10 returns the match value minus the remaining countdown, modulo 2^DATA_W.
- R5: On the tick that ends the countdown, the settled count becomes equal to the match value.
- R6: At expiry, if the enable register is nonzero, the status flag (bit 0 of offset 0x14) and `irq` go high on that same edge. If the enable register is zero, neither changes.
- R7: Writing zero to offset 0x14 clears the status flag and `irq`. A nonzero write to offset 0x14 leaves the flag unchanged. An expiry in the same cycle takes priority over the clear.
- R8: Offset 0x1C holds the full-width enable word, which is written and read back unchanged.
- R9: Reads of offset 0x00 and of every unmapped offset return zero. Writes to unmapped offsets and to offset 0x10 have no effect.
- R10: A match write while a countdown is running replaces it. The new length is computed from the settled count, not from the live count.
- R11: `irq` always equals the status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Counting-rate strobe, one tick per high cycle |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Combinational read data for busAddr |
| irq | output | 1 | Level interrupt, follows the status flag |

## Verification
The bench builds the timer with DATA_W = 12 and the default ADDR_W = 8, so the full counter range is only 4096 ticks. This makes the wraparound distance rule reachable within the run. It also makes the zero-length countdown reachable: that case needs a settled count of all ones followed by a match of zero. With the narrow width, the bench can also show the one-tick offset that the wrap rule puts into the live count read right after arming.

// File: rtl/ostm_pkg.sv
package ostm_pkg;
  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic armMatch;   // match-register write this cycle
    logic countTick;  // counting-rate tick this cycle
  } dpStrobe_t;
endpackage

// File: rtl/ostm_datapath.sv
module ostm_datapath
  import ostm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  output logic              expire,
  output logic [DATA_W-1:0] countView
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;
  localparam logic [DATA_W-1:0] ONE      = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] matchReg;
  logic [DATA_W-1:0] countReg;
  logic [DATA_W-1:0] remainReg;
  logic [DATA_W-1:0] armDistance;
  logic              running;

  // Distance from the settled count to the new match, wrapping past all-ones.
  always_comb begin
    if (wrData > countReg) armDistance = wrData - countReg;
    else                   armDistance = wrData + (ALL_ONES - countReg);
  end

  // A match write in the same cycle wins over an expiring tick.
  assign expire    = running && strb.countTick && !strb.armMatch && (remainReg <= ONE);
  assign countView = matchReg - remainReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchReg  <= '0;
      countReg  <= '0;
      remainReg <= '0;
      running   <= 1'b0;
    end else if (strb.armMatch) begin
      matchReg  <= wrData;
      remainReg <= armDistance;
      running   <= 1'b1;
    end else if (expire) begin
      countReg  <= matchReg;
      remainReg <= '0;
      running   <= 1'b0;
    end else if (running && strb.countTick) begin
      remainReg <= remainReg - ONE;
    end
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !strb.armMatch) |=> ($stable(remainReg) && $stable(countReg)));

  // R5
  snap_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (countReg == $past(matchReg) && !running));

  // R2
  arm_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.armMatch |=> (running && matchReg == $past(wrData)));

  // R3
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countTick && !strb.armMatch) |=> $stable(remainReg));
endmodule

// File: rtl/ostm_ctrl.sv
module ostm_ctrl
  import ostm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              expire,
  input  logic [DATA_W-1:0] countView,
  output dpStrobe_t         strb,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFF_MATCH  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_COUNT  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFF_STATUS = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFF_ENABLE = ADDR_W'(8'h1C);

  logic              statusFlag;
  logic [DATA_W-1:0] enableReg;
  logic              hitMatch, hitStatus, hitEnable;
  logic              intrOn;
  logic              ackWrite;

  assign hitMatch  = (busAddr == OFF_MATCH);
  assign hitStatus = (busAddr == OFF_STATUS);
  assign hitEnable = (busAddr == OFF_ENABLE);
  assign intrOn    = (enableReg != '0);
  assign ackWrite  = busWrEn && hitStatus && (busWrData == '0);

  assign strb.armMatch  = busWrEn && hitMatch;
  assign strb.countTick = tickEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusFlag <= 1'b0;
      enableReg  <= '0;
    end else begin
      if (expire && intrOn)  statusFlag <= 1'b1;
      else if (ackWrite)     statusFlag <= 1'b0;
      if (busWrEn && hitEnable) enableReg <= busWrData;
    end
  end

  always_comb begin
    case (busAddr)
      OFF_COUNT:  busRdData = countView;
      OFF_STATUS: busRdData = {{(DATA_W-1){1'b0}}, statusFlag};
      OFF_ENABLE: busRdData = enableReg;
      default:    busRdData = '0;
    endcase
  end

  assign irq = statusFlag;

  // R6
  status_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expire && intrOn) |=> statusFlag);

  // R6
  masked_expiry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !intrOn && !statusFlag) |=> !statusFlag);

  // R7
  status_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackWrite && !expire) |=> !statusFlag);

  // R7
  status_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && hitStatus && busWrData != '0) |=> $stable(statusFlag) || statusFlag);
endmodule

// File: rtl/match_os_timer.sv
module match_os_timer
  import ostm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq
);
  dpStrobe_t         strb;
  logic              expire;
  logic [DATA_W-1:0] countView;

  ostm_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .expire(expire),
    .countView(countView), .strb(strb), .busRdData(busRdData), .irq(irq)
  );

  ostm_datapath #(.DATA_W(DATA_W)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData),
    .expire(expire), .countView(countView)
  );
endmodule

// File: tb/match_os_timer_test.sv
module match_os_timer_test;
  localparam int W = 12;
  localparam int A = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         tickEn = 1'b0;
  logic [A-1:0] busAddr = '0;
  logic         busWrEn = 1'b0;
  logic [W-1:0] busWrData = '0;
  logic [W-1:0] busRdData;
  logic         irq;

  int vectors = 0;
  int miscompares = 0;

  match_os_timer #(.DATA_W(W), .ADDR_W(A)) uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input int addr, input int data);
    @(negedge clk);
    busAddr = A'(addr); busWrData = W'(data); busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic readChk(input string tag, input int addr, input int exp);
    busAddr = A'(addr);
    #1;
    check(tag, int'(busRdData), exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
    end
    @(negedge clk); tickEn = 1'b0;
  endtask

  task automatic clearStatus();
    busWrite('h14, 0);
  endtask

  task automatic tReset();
    readChk("R1 match reads zero (R9)", 'h00, 0);
    readChk("R1 count", 'h10, 0);
    readChk("R1 status", 'h14, 0);
    readChk("R1 enable", 'h1C, 0);
    check("R1 irq", int'(irq), 0);
  endtask

  task automatic tEnable();
    busWrite('h1C, 'hABC);
    readChk("R8 enable readback", 'h1C, 'hABC);
    busWrite('h1C, 1);
    readChk("R8 enable rewrite", 'h1C, 1);
  endtask

  task automatic tBasic();
    busWrite('h00, 10);
    readChk("R4 count after arm", 'h10, 0);
    ticks(3);
    readChk("R3 count after 3 ticks", 'h10, 3);
    repeat (5) @(negedge clk);
    readChk("R3 no tick holds", 'h10, 3);
    ticks(6);
    readChk("R4 count before expiry", 'h10, 9);
    check("R6 irq before expiry", int'(irq), 0);
    ticks(1);
    readChk("R5 count at expiry", 'h10, 10);
    readChk("R6 status at expiry", 'h14, 1);
    check("R11 irq follows status", int'(irq), 1);
    ticks(20);
    readChk("R3 one-shot stays", 'h10, 10);
  endtask

  task automatic tStatus();
    busWrite('h14, 5);
    readChk("R7 nonzero write ignored", 'h14, 1);
    check("R7 irq kept", int'(irq), 1);
    clearStatus();
    readChk("R7 clear", 'h14, 0);
    check("R11 irq cleared", int'(irq), 0);
  endtask

  task automatic tWrap();
    // count 10, match 4: 4 + (0xFFF - 10) = 4089 ticks
    busWrite('h00, 4);
    readChk("R2 wrap count view", 'h10, 11);
    ticks(4088);
    readChk("R2 wrap one tick left", 'h10, 3);
    check("R2 wrap no irq yet", int'(irq), 0);
    ticks(1);
    readChk("R5 wrap snapped", 'h10, 4);
    check("R6 wrap irq", int'(irq), 1);
    clearStatus();
  endtask

  task automatic tDisabled();
    busWrite('h1C, 0);
    busWrite('h00, 20);
    ticks(16);
    readChk("R5 masked expiry count", 'h10, 20);
    readChk("R6 masked status", 'h14, 0);
    check("R6 masked irq", int'(irq), 0);
    busWrite('h1C, 1);
  endtask

  task automatic tZero();
    busWrite('h00, 'hFFF);
    ticks(4075);
    readChk("R5 count at all ones", 'h10, 'hFFF);
    clearStatus();
    busWrite('h00, 0);
    readChk("R2 zero length view", 'h10, 0);
    check("R2 zero length not yet", int'(irq), 0);
    ticks(1);
    check("R2 zero length expires on first tick", int'(irq), 1);
    readChk("R5 zero length count", 'h10, 0);
    clearStatus();
  endtask

  task automatic tRearm();
    busWrite('h00, 100);
    ticks(5);
    readChk("R4 running view", 'h10, 5);
    busWrite('h00, 50);
    readChk("R10 rearm from settled count", 'h10, 0);
    ticks(49);
    readChk("R10 rearm count", 'h10, 49);
    check("R10 no early irq", int'(irq), 0);
    ticks(1);
    check("R10 irq after new length", int'(irq), 1);
    readChk("R10 snapped", 'h10, 50);
    clearStatus();
  endtask

  task automatic tUnmapped();
    busWrite('h04, 'h123);
    busWrite('h18, 'h7);
    busWrite('h10, 'h321);
    readChk("R9 unmapped 04 reads zero", 'h04, 0);
    readChk("R9 unmapped 18 reads zero", 'h18, 0);
    readChk("R9 enable untouched", 'h1C, 1);
    readChk("R9 count untouched", 'h10, 50);
    readChk("R9 status untouched", 'h14, 0);
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tEnable();
    tBasic();
    tStatus();
    tWrap();
    tDisabled();
    tZero();
    tRearm();
    tUnmapped();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule